// File: doc/BRIEF.md
# Dual-Channel Reload Timer

This block holds two down-counting timer channels of `CNT_W` bits each (16 by default) and one shared 8-bit control and status byte. Each channel has a count register and a reload register. Software reads and writes both one byte at a time through a plain read/write strobe interface. While a channel's count enable is set, the counter steps down by one on every pulse of the `cnt_tick` strobe. A pulse that brings it to zero raises the channel's flag. The next pulse loads the reload value, and counting carries on from there.

Each channel raises an interrupt request while both its flag and its interrupt enable are set. A flag cannot be cleared by a write. It clears only through a two-step read: first the control byte, then either byte of that channel's counter. Channel 1 also drives an output pin that is shared with an address line. A 2-bit mode field either hands the pin to the address line or drives it from the timer. The timer can drive it low, drive it high, or toggle it on every zero of channel 1.

Top module: `dual_reload_timer`

## Requirements
- R1: A read of address 0 returns the control byte: bit 7 is flag 1, bit 6 is flag 0, bits 5:4 are the interrupt enables (ch1, ch0), bits 3:2 are the pin mode and bits 1:0 are the count enables (ch1, ch0). A write to address 0 updates bits 5:0 and leaves the flags unchanged.
- R2: After reset, every flag, enable and pin-mode bit is 0, every counter and reload byte reads 0, both requests are low and the pin follows `addr_line_in`.
- R3: While a channel's count enable is 1, each `cnt_tick` pulse lowers a nonzero counter by one. Cycles without a pulse leave it unchanged.
- R4: The pulse that lowers a counter from 1 to 0 sets that channel's flag. The next pulse loads the 16-bit reload value.
- R5: While a channel's count enable is 0, its counter holds its value and accepts byte writes. While the enable is 1, writes to its counter bytes are ignored. Reload bytes are writable at all times.
- R6: `irq[n]` is high exactly while flag n and interrupt enable n are both 1.
- R7: A read of the control byte arms both channels. A read of either counter byte of an armed channel clears that channel's flag and disarms it. A counter read of a channel that is not armed leaves its flag set. A read of the other channel does not disarm it.
- R8: If the clearing read falls in the same cycle as a zero event of that channel, the flag stays set.
- R9: Pin mode 00 passes `addr_line_in` to `tout_pin`, 01 outputs the toggle bit, 10 drives 0 and 11 drives 1.
- R10: The toggle bit resets to 0 and inverts on each zero event of channel 1, and at no other time.
- R11: Byte addresses are: 1/2 for the channel 0 counter low/high bytes, 3/4 for the channel 0 reload low/high bytes, 5/6 for the channel 1 counter, 7/8 for the channel 1 reload. All other addresses read 0. `rdata` is 0 while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Count strobe, one pulse per count step |
| rd_en | input | 1 | Read strobe for the byte at `addr` |
| wr_en | input | 1 | Write strobe for the byte at `addr` |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| addr_line_in | input | 1 | Address signal that shares the output pin |
| tout_pin | output | 1 | Shared pin: address line or timer output |
| irq | output | 2 | Per-channel interrupt request |

## Verification
The hardest case to reach is the collision in R8, where a clearing read lands in exactly the cycle of a zero event. The flag must already be set and armed, and the counter must sit at 1. The stimulus sets the reload value to 1 so that zeros recur every second pulse. It then reads the control byte between two zeros and issues the counter read together with the pulse that produces the next zero. A companion sequence shows that arming survives a read of the other channel and is lost after a read of the channel itself.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;

  typedef enum logic [1:0] {
    PIN_ADDR   = 2'b00,
    PIN_TOGGLE = 2'b01,
    PIN_LOW    = 2'b10,
    PIN_HIGH   = 2'b11
  } pin_mode_e;

  // Control byte layout: flags, enables, pin mode, count enables.
  function automatic logic [7:0] pack_ctrl(input logic [1:0] flag,
                                           input logic [1:0] ie,
                                           input logic [1:0] mode,
                                           input logic [1:0] de);
    return {flag, ie, mode, de};
  endfunction

  function automatic logic pin_pick(input pin_mode_e mode,
                                    input logic addr_bit,
                                    input logic tgl);
    logic r;
    case (mode)
      PIN_ADDR:   r = addr_bit;
      PIN_TOGGLE: r = tgl;
      PIN_LOW:    r = 1'b0;
      default:    r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/timer_channel.sv
module timer_channel #(
  parameter int CNT_W = 16,
  localparam int NB = CNT_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_en,
  input  logic [NB-1:0]    cnt_wr_be,
  input  logic [NB-1:0]    rld_wr_be,
  input  logic [7:0]       wdata,
  input  logic             data_rd,
  input  logic             arm_set,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] rld_q,
  output logic             flag_q,
  output logic             armed_q,
  output logic             zero_evt
);

  function automatic logic [CNT_W-1:0] count_next(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] r);
    return (c == '0) ? r : c - CNT_W'(1);
  endfunction

  function automatic logic about_to_zero(input logic [CNT_W-1:0] c);
    return c == CNT_W'(1);
  endfunction

  logic stepping;
  assign stepping = cnt_en && tick;
  assign zero_evt = stepping && about_to_zero(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (stepping) begin
      cnt_q <= count_next(cnt_q, rld_q);
    end else if (!cnt_en) begin
      for (int b = 0; b < NB; b++) begin
        if (cnt_wr_be[b]) cnt_q[b*8 +: 8] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_q <= '0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (rld_wr_be[b]) rld_q[b*8 +: 8] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (zero_evt)                flag_q <= 1'b1;
      else if (armed_q && data_rd) flag_q <= 1'b0;
      if (arm_set)                 armed_q <= 1'b1;
      else if (data_rd)            armed_q <= 1'b0;
    end
  end

endmodule

// File: rtl/timer_out_mux.sv
module timer_out_mux
  import dtimer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       zero_evt,
  input  logic [1:0] mode,
  input  logic       addr_line,
  output logic       tgl_q,
  output logic       pin
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tgl_q <= 1'b0;
    else if (zero_evt) tgl_q <= ~tgl_q;
  end

  assign pin = pin_pick(pin_mode_e'(mode), addr_line, tgl_q);

endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import dtimer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_tick,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              addr_line_in,
  output logic              tout_pin,
  output logic [1:0]        irq
);

  localparam int NB      = CNT_W / 8;
  localparam int CH_SPAN = 2 * NB;
  localparam int NCH     = 2;

  logic [1:0] de, ie, mode;
  logic [NCH-1:0][CNT_W-1:0] cnt, rld;
  logic [NCH-1:0] flag, armed, zero_evt, data_rd, cnt_wr;
  logic ctrl_rd, ctrl_wr, tgl;

  assign ctrl_rd = rd_en && (addr == '0);
  assign ctrl_wr = wr_en && (addr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de   <= '0;
      ie   <= '0;
      mode <= '0;
    end else if (ctrl_wr) begin
      ie   <= wdata[5:4];
      mode <= wdata[3:2];
      de   <= wdata[1:0];
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam int CBASE = 1 + n * CH_SPAN;
    localparam int RBASE = CBASE + NB;
    logic [NB-1:0] cwr, rwr, crd;
    for (genvar b = 0; b < NB; b++) begin : g_b
      assign cwr[b] = wr_en && (addr == ADDR_W'(CBASE + b));
      assign rwr[b] = wr_en && (addr == ADDR_W'(RBASE + b));
      assign crd[b] = rd_en && (addr == ADDR_W'(CBASE + b));
    end
    assign data_rd[n] = |crd;
    assign cnt_wr[n]  = |cwr;

    timer_channel #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (cnt_tick),
      .cnt_en   (de[n]),
      .cnt_wr_be(cwr),
      .rld_wr_be(rwr),
      .wdata    (wdata),
      .data_rd  (data_rd[n]),
      .arm_set  (ctrl_rd),
      .cnt_q    (cnt[n]),
      .rld_q    (rld[n]),
      .flag_q   (flag[n]),
      .armed_q  (armed[n]),
      .zero_evt (zero_evt[n])
    );
  end

  timer_out_mux u_pin (
    .clk      (clk),
    .rst_n    (rst_n),
    .zero_evt (zero_evt[1]),
    .mode     (mode),
    .addr_line(addr_line_in),
    .tgl_q    (tgl),
    .pin      (tout_pin)
  );

  assign irq = flag & ie;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == '0) rdata = pack_ctrl(flag, ie, mode, de);
      for (int n = 0; n < NCH; n++) begin
        for (int b = 0; b < NB; b++) begin
          if (addr == ADDR_W'(1 + n * CH_SPAN + b))      rdata = cnt[n][b*8 +: 8];
          if (addr == ADDR_W'(1 + n * CH_SPAN + NB + b)) rdata = rld[n][b*8 +: 8];
        end
      end
    end
  end

endmodule

// File: rtl/dtimer_chk.sv
module dtimer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [1:0]       zero_evt,
  input logic [1:0]       flag,
  input logic [1:0]       armed,
  input logic [1:0]       data_rd,
  input logic [1:0]       ie,
  input logic [1:0]       de,
  input logic [1:0]       irq,
  input logic [1:0]       cnt_wr,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] cnt1,
  input logic             tgl
);

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (de[0] && tick && cnt0 != '0) |=> (cnt0 == $past(cnt0) - CNT_W'(1)));

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt[0] |=> flag[0]);

  assert_flag_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag[1] && !zero_evt[1]) |=> !flag[1]);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!de[1] && !cnt_wr[1]) |=> $stable(cnt1));

  assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] == (flag[0] && ie[0]));

  assert_flag_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag[0] && !(armed[0] && data_rd[0])) |=> flag[0]);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt[1] && armed[1] && data_rd[1]) |=> flag[1]);

  assert_tgl_still_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_evt[1] |=> $stable(tgl));

endmodule

bind dual_reload_timer dtimer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (cnt_tick),
  .zero_evt(zero_evt),
  .flag    (flag),
  .armed   (armed),
  .data_rd (data_rd),
  .ie      (ie),
  .de      (de),
  .irq     (irq),
  .cnt_wr  (cnt_wr),
  .cnt0    (cnt[0]),
  .cnt1    (cnt[1]),
  .tgl     (tgl)
);

// File: tb/tb_dual_reload_timer.sv
module tb_dual_reload_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_tick = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       addr_line_in = 1'b0;
  logic       tout_pin;
  logic [1:0] irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_reload_timer dut (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .rd_en(rd_en),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .addr_line_in(addr_line_in), .tout_pin(tout_pin), .irq(irq)
  );

  // Behavioural reference model
  int m_cnt[2], m_rld[2];
  bit m_flag[2], m_arm[2];
  bit [1:0] m_ie, m_de, m_mode;
  bit m_tgl;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < 2; n++) begin
        m_cnt[n] = 0; m_rld[n] = 0; m_flag[n] = 0; m_arm[n] = 0;
      end
      m_ie = 0; m_de = 0; m_mode = 0; m_tgl = 0;
    end else begin
      bit [1:0] old_de;
      old_de = m_de;
      for (int n = 0; n < 2; n++) begin
        bit hit, rd_me;
        int base;
        base = 1 + 4 * n;
        hit = 0;
        rd_me = rd_en && (addr == base || addr == base + 1);
        if (old_de[n] && cnt_tick) begin
          if (m_cnt[n] == 0) m_cnt[n] = m_rld[n];
          else begin
            m_cnt[n] = m_cnt[n] - 1;
            hit = (m_cnt[n] == 0);
          end
        end else if (!old_de[n] && wr_en) begin
          if (addr == base)     m_cnt[n] = (m_cnt[n] & 'hFF00) | wdata;
          if (addr == base + 1) m_cnt[n] = (m_cnt[n] & 'h00FF) | (int'(wdata) << 8);
        end
        if (wr_en && addr == base + 2) m_rld[n] = (m_rld[n] & 'hFF00) | wdata;
        if (wr_en && addr == base + 3) m_rld[n] = (m_rld[n] & 'h00FF) | (int'(wdata) << 8);
        if (hit) m_flag[n] = 1;
        else if (m_arm[n] && rd_me) m_flag[n] = 0;
        if (rd_en && addr == 0) m_arm[n] = 1;
        else if (rd_me) m_arm[n] = 0;
        if (hit && n == 1) m_tgl = ~m_tgl;
      end
      if (wr_en && addr == 0) begin
        m_ie = wdata[5:4]; m_mode = wdata[3:2]; m_de = wdata[1:0];
      end
    end
  end

  function automatic logic [7:0] m_rdata();
    int n, off;
    if (!rd_en) return 8'h00;
    if (addr == 0) return {m_flag[1], m_flag[0], m_ie, m_mode, m_de};
    if (addr > 8) return 8'h00;
    n = (int'(addr) - 1) / 4;
    off = (int'(addr) - 1) % 4;
    case (off)
      0: return 8'(m_cnt[n]);
      1: return 8'(m_cnt[n] >> 8);
      2: return 8'(m_rld[n]);
      default: return 8'(m_rld[n] >> 8);
    endcase
  endfunction

  function automatic logic m_pin();
    case (m_mode)
      2'b00: return addr_line_in;
      2'b01: return m_tgl;
      2'b10: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      check(int'(irq), int'({m_flag[1] & m_ie[1], m_flag[0] & m_ie[0]}), "R6 irq vs model");
      check(int'(tout_pin), int'(m_pin()), "R9 pin vs model");
      check(int'(rdata), int'(m_rdata()), "R11 rdata vs model");
    end
  end

  task automatic step(input bit t, input bit r, input bit w,
                      input int a, input int d);
    @(negedge clk);
    cnt_tick = t; rd_en = r; wr_en = w; addr = 4'(a); wdata = 8'(d);
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0); endtask
  task automatic tick(); step(1, 0, 0, 0, 0); endtask
  task automatic wr(input int a, input int d); step(0, 0, 1, a, d); endtask

  task automatic expect_rd(input int a, input int exp, input string tag);
    step(0, 1, 0, a, 0);
    #1 check(int'(rdata), exp, tag);
  endtask

  task automatic expect_irq(input int exp, input string tag);
    idle();
    #1 check(int'(irq), exp, tag);
  endtask

  task automatic expect_pin(input int exp, input string tag);
    idle();
    #1 check(int'(tout_pin), exp, tag);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    expect_rd(0, 8'h00, "R2 ctrl reset");
    expect_rd(1, 8'h00, "R2 counter reset");
    expect_irq(0, "R2 irq reset");
    addr_line_in = 1'b1;
    expect_pin(1, "R2 pin follows address");
    addr_line_in = 1'b0;

    // Channel 0: reload 3, start at 2
    wr(3, 8'h03); wr(4, 8'h00); wr(1, 8'h02); wr(2, 8'h00);
    expect_rd(1, 8'h02, "R5 write while stopped");
    wr(0, 8'h11);
    tick();
    expect_rd(1, 8'h01, "R3 decrement");
    idle();
    expect_rd(1, 8'h01, "R3 hold without pulse");
    tick();
    expect_irq(1, "R4 zero sets flag / R6 request");
    expect_rd(0, 8'h51, "R1 control layout");
    tick();
    expect_rd(2, 8'h00, "R7 armed read high byte");
    expect_irq(0, "R7 flag cleared");
    expect_rd(1, 8'h03, "R4 reload value");

    // Read without arming, other-channel read
    tick(); tick(); tick();
    expect_rd(1, 8'h00, "R7 read without arm");
    expect_irq(1, "R7 flag kept");
    expect_rd(0, 8'h51, "R1 flag visible");
    expect_rd(5, 8'h00, "R11 ch1 counter byte");
    expect_irq(1, "R7 other channel read");
    expect_rd(1, 8'h00, "R7 still armed");
    expect_irq(0, "R7 cleared after arm kept");

    // Writes ignored while counting; hold while stopped
    wr(1, 8'h55);
    expect_rd(1, 8'h00, "R5 write ignored while counting");
    wr(0, 8'h10);
    wr(1, 8'h07);
    tick(); tick(); tick();
    expect_rd(1, 8'h07, "R5 hold while stopped");

    // Interrupt gating
    wr(1, 8'h01);
    wr(0, 8'h01);
    tick();
    expect_irq(0, "R6 masked request");
    wr(0, 8'h11);
    expect_irq(1, "R6 enabled request");
    expect_rd(0, 8'h51, "R1 arm");
    expect_rd(1, 8'h00, "R7 clear");
    wr(0, 8'hD1);
    expect_rd(0, 8'h11, "R1 flag bits read-only");

    // R8 collision: zeros every second pulse
    wr(3, 8'h01);
    tick();
    tick();
    expect_rd(0, 8'h51, "R8 arm with flag set");
    tick();
    step(1, 1, 0, 1, 0);
    expect_rd(0, 8'h51, "R8 set beats clear");
    wr(0, 8'h00);

    // Channel 1 pin modes
    wr(0, 8'h08);
    addr_line_in = 1'b1;
    expect_pin(0, "R9 forced low");
    wr(0, 8'h0C);
    addr_line_in = 1'b0;
    expect_pin(1, "R9 forced high");
    wr(7, 8'h02); wr(8, 8'h00); wr(5, 8'h01);
    wr(0, 8'h06);
    expect_pin(0, "R10 toggle reset value");
    tick();
    expect_pin(1, "R10 toggle on zero");
    tick(); tick();
    expect_pin(1, "R10 no toggle between zeros");
    tick();
    expect_pin(0, "R10 toggle on second zero");
    wr(0, 8'h02);
    addr_line_in = 1'b1;
    expect_pin(1, "R9 address mode");
    addr_line_in = 1'b0;

    expect_rd(7, 8'h02, "R11 reload readback");
    expect_rd(9, 8'h00, "R11 unused address");
    step(0, 0, 0, 7, 0);
    #1 check(int'(rdata), 0, "R11 no read strobe");
    idle();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule